// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

The detector sits behind a receive MAC and watches each incoming frame one byte at a time. It looks for a wake pattern: a run of 0xFF synchronization bytes followed directly by a fixed number of back-to-back copies of the station's node address. The pattern may begin at any byte of the frame. Bytes before and after the pattern are ignored.

A pattern found inside a frame is only remembered at first. A wake request is raised when that frame closes with a good CRC and the MAC reports that the destination address was accepted. The MAC may accept the frame as unicast to this node, as multicast, or as broadcast. The request drives an active-low power-management event line. The line stays low until software pulses the clear input or the block is reset.

Detection is armed only while both the global power-management enable and the magic-packet enable are high.

Top module: `wol_magic_detect`

## Requirements
- R1: `pme_n_o` never goes low while `pm_en_i` or `magic_en_i` is 0. Both must be 1 for a frame to cause a wake.
- R2: The sync is at least SYNC_LEN (6) consecutive 0xFF bytes. A longer run is also a valid sync, for example a 17-byte run. The last SYNC_LEN bytes of the run count as the sync.
- R3: The sync must be followed directly by REPS (16) copies of the node address, with no gaps. Address byte k is `node_addr_i[8k+7:8k]`, and byte 0 is sent first. For 48'h665544332211, each copy is 11 22 33 44 55 66. Copies sent in the reverse byte order do not match.
- R4: The sync plus the address copies is found at any byte offset of the frame. This includes the first payload byte and positions deep in the payload.
- R5: A mismatch during the address copies abandons the attempt. The mismatching byte is then evaluated again as a possible first sync byte. A single corrupted byte anywhere in the copies prevents a wake. A full pattern that starts right after a partial match is still found.
- R6: A wake is signalled only on the frame's last byte, and only when `rx_crc_ok_i` and `rx_addr_hit_i` are both 1 with that byte. `pme_n_o` goes low in the cycle after the clock edge that takes the last byte.
- R7: A frame that ends before all REPS copies are complete, for example after 15 copies, leaves no wake pending.
- R8: Once low, `pme_n_o` stays low until a cycle with `pme_clr_i` = 1 returns it high. A wake and a clear in the same cycle leave it low.
- R9: Each start-of-frame resets all scanning state, so a pattern split across two frames is not found. Bytes received outside a frame, that is without a preceding start-of-frame, are ignored.
- R10: After reset, `pme_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pm_en_i | input | 1 | Global power-management enable |
| magic_en_i | input | 1 | Magic-packet wake enable |
| node_addr_i | input | 8*ADDR_BYTES | Node address; byte 0 in bits 7:0 |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | First byte of frame, qualified by valid |
| rx_eof_i | input | 1 | Last byte of frame, qualified by valid |
| rx_data_i | input | 8 | Receive byte |
| rx_crc_ok_i | input | 1 | Frame CRC good, sampled with the last byte |
| rx_addr_hit_i | input | 1 | Destination accepted (unicast, multicast or broadcast), sampled with the last byte |
| pme_clr_i | input | 1 | Clear the pending wake event |
| pme_n_o | output | 1 | Power-management event, active low, sticky |

## Verification
The bench builds the detector with its default parameters: a 6-byte sync, a 6-byte address and 16 copies. A complete pattern is therefore 102 bytes, and every scenario fits in a frame of under 200 bytes. These values reach the saturation of the sync counter with a 17-byte 0xFF prefix. They also reach the wrap of the copy counter at its last value, and a failure at copy 15 one step before completion. The node address 11:22:33:44:55:66 contains no 0xFF, which makes a byte-order mistake show up as a missed wake.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hFF;

  typedef enum logic {
    PH_SYNC = 1'b0,
    PH_ADDR = 1'b1
  } scan_phase_e;
endpackage

// File: rtl/wol_frame_track.sv
module wol_frame_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sof_i,
  input  logic eof_i,
  output logic byte_ok_o,
  output logic start_o,
  output logic end_o
);
  logic in_frame_q;

  assign start_o   = valid_i && sof_i;
  assign byte_ok_o = valid_i && (sof_i || in_frame_q);
  assign end_o     = byte_ok_o && eof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                in_frame_q <= 1'b0;
    else if (valid_i && eof_i)  in_frame_q <= 1'b0;
    else if (valid_i && sof_i)  in_frame_q <= 1'b1;
  end

  AST_EOF_CLOSES_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i) |=> !in_frame_q); // R9
endmodule

// File: rtl/wol_sync_scan.sv
module wol_sync_scan import wol_pkg::*; #(
  parameter int unsigned SYNC_LEN   = 6,
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned REPS       = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         step_i,
  input  logic                         start_i,
  input  logic [BYTE_W-1:0]            data_i,
  input  logic [ADDR_BYTES*BYTE_W-1:0] node_addr_i,
  output logic                         found_o
);
  localparam int unsigned RUN_W = $clog2(SYNC_LEN + 1);
  localparam int unsigned IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int unsigned REP_W = (REPS > 1) ? $clog2(REPS) : 1;
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(SYNC_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);
  localparam logic [REP_W-1:0] LAST_REP = REP_W'(REPS - 1);

  logic [BYTE_W-1:0] addr_byte [ADDR_BYTES];
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr_byte
    assign addr_byte[g] = node_addr_i[g*BYTE_W +: BYTE_W];
  end

  logic [RUN_W-1:0] run_q, run_b, run_n;
  logic [IDX_W-1:0] idx_q, idx_b, idx_n;
  logic [REP_W-1:0] rep_q, rep_b, rep_n;
  scan_phase_e      phase_q, phase_b, phase_n;
  logic             found_q, found_b, found_n;
  logic             hit, sync_ok, lead_ok, is_sync;

  always_comb begin
    run_b   = start_i ? '0      : run_q;
    idx_b   = start_i ? '0      : idx_q;
    rep_b   = start_i ? '0      : rep_q;
    phase_b = start_i ? PH_SYNC : phase_q;
    found_b = start_i ? 1'b0    : found_q;

    sync_ok = (run_b == RUN_FULL);
    is_sync = (data_i == SYNC_BYTE);
    lead_ok = sync_ok && (data_i == addr_byte[0]);

    run_n   = run_b;
    idx_n   = idx_b;
    rep_n   = rep_b;
    phase_n = phase_b;
    found_n = found_b;
    hit     = 1'b0;

    if (step_i) begin
      // consecutive 0xFF count runs in both phases; saturates at SYNC_LEN
      run_n = !is_sync ? '0 : (sync_ok ? run_b : run_b + RUN_W'(1));
      if (!found_b) begin
        if (phase_b == PH_ADDR && data_i == addr_byte[idx_b]) begin
          if (idx_b == LAST_IDX) begin
            idx_n = '0;
            if (rep_b == LAST_REP) begin
              hit     = 1'b1;
              found_n = 1'b1;
              phase_n = PH_SYNC;
              rep_n   = '0;
            end else begin
              rep_n = rep_b + REP_W'(1);
            end
          end else begin
            idx_n = idx_b + IDX_W'(1);
          end
        end else if (lead_ok) begin
          // mismatching or sync-phase byte reused as first address byte
          phase_n = PH_ADDR;
          idx_n   = IDX_W'(1);
          rep_n   = '0;
        end else begin
          phase_n = PH_SYNC;
          idx_n   = '0;
          rep_n   = '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      idx_q   <= '0;
      rep_q   <= '0;
      phase_q <= PH_SYNC;
      found_q <= 1'b0;
    end else if (step_i || start_i) begin
      run_q   <= run_n;
      idx_q   <= idx_n;
      rep_q   <= rep_n;
      phase_q <= phase_n;
      found_q <= found_n;
    end
  end

  assign found_o = found_b || hit;

  AST_ADDR_AFTER_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_q == PH_ADDR) |-> ($past(run_q) == RUN_FULL)); // R2
  AST_SOF_CLEARS_FOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !found_q); // R9
  AST_NO_STEP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !start_i) |=> $stable(found_q)); // R1
endmodule

// File: rtl/wol_wake_ctrl.sv
module wol_wake_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic end_i,
  input  logic crc_ok_i,
  input  logic addr_hit_i,
  input  logic found_i,
  input  logic clr_i,
  output logic pme_n_o
);
  logic set;
  logic pme_n_q;

  assign set = arm_i && end_i && found_i && crc_ok_i && addr_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pme_n_q <= 1'b1;
    else if (set)   pme_n_q <= 1'b0;
    else if (clr_i) pme_n_q <= 1'b1;
  end

  assign pme_n_o = pme_n_q;

  AST_WAKE_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pme_n_o) |-> $past(arm_i)); // R1
  AST_WAKE_AT_GOOD_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pme_n_o) |-> $past(end_i && crc_ok_i && addr_hit_i)); // R6
  AST_WAKE_NEEDS_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pme_n_o) |-> $past(found_i)); // R7
  AST_STICKY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pme_n_o && !clr_i) |=> !pme_n_o); // R8
  AST_CLEAR_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !end_i) |=> pme_n_o); // R8
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect import wol_pkg::*; #(
  parameter int unsigned SYNC_LEN   = 6,
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned REPS       = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         pm_en_i,
  input  logic                         magic_en_i,
  input  logic [ADDR_BYTES*BYTE_W-1:0] node_addr_i,
  input  logic                         rx_valid_i,
  input  logic                         rx_sof_i,
  input  logic                         rx_eof_i,
  input  logic [BYTE_W-1:0]            rx_data_i,
  input  logic                         rx_crc_ok_i,
  input  logic                         rx_addr_hit_i,
  input  logic                         pme_clr_i,
  output logic                         pme_n_o
);
  logic arm, byte_ok, frame_start, frame_end, found;

  assign arm = pm_en_i && magic_en_i;

  wol_frame_track u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (rx_valid_i),
    .sof_i     (rx_sof_i),
    .eof_i     (rx_eof_i),
    .byte_ok_o (byte_ok),
    .start_o   (frame_start),
    .end_o     (frame_end)
  );

  wol_sync_scan #(
    .SYNC_LEN   (SYNC_LEN),
    .ADDR_BYTES (ADDR_BYTES),
    .REPS       (REPS)
  ) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (byte_ok && arm),
    .start_i     (frame_start),
    .data_i      (rx_data_i),
    .node_addr_i (node_addr_i),
    .found_o     (found)
  );

  wol_wake_ctrl u_wake (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm),
    .end_i      (frame_end),
    .crc_ok_i   (rx_crc_ok_i),
    .addr_hit_i (rx_addr_hit_i),
    .found_i    (found),
    .clr_i      (pme_clr_i),
    .pme_n_o    (pme_n_o)
  );
endmodule

// File: tb/wol_magic_detect_tb.sv
module wol_magic_detect_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [47:0] NODE = 48'h665544332211;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pm_en_i = 1'b1, magic_en_i = 1'b1;
  logic rx_valid_i = 1'b0, rx_sof_i = 1'b0, rx_eof_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic rx_crc_ok_i = 1'b0, rx_addr_hit_i = 1'b0, pme_clr_i = 1'b0;
  logic pme_n_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] frm [0:511];
  int flen = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wol_magic_detect dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pm_en_i(pm_en_i), .magic_en_i(magic_en_i),
    .node_addr_i(NODE), .rx_valid_i(rx_valid_i), .rx_sof_i(rx_sof_i),
    .rx_eof_i(rx_eof_i), .rx_data_i(rx_data_i), .rx_crc_ok_i(rx_crc_ok_i),
    .rx_addr_hit_i(rx_addr_hit_i), .pme_clr_i(pme_clr_i), .pme_n_o(pme_n_o)
  );

  task automatic chk_pme(input logic exp, input string tag);
    checks++;
    if (pme_n_o !== exp) begin
      fails++;
      $display("FAIL %s: pme_n_o=%b expected %b", tag, pme_n_o, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    frm[flen] = b;
    flen++;
  endtask

  task automatic add_hdr(input bit bcast);
    flen = 0;
    for (int i = 0; i < 6; i++) put(bcast ? 8'hFF : (i == 0 ? 8'h01 : 8'h5E));
    put(8'h02); for (int i = 0; i < 4; i++) put(8'h00); put(8'h01);
    put(8'h08); put(8'h42);
  endtask

  task automatic add_sync(input int n);
    for (int i = 0; i < n; i++) put(8'hFF);
  endtask

  task automatic add_reps(input int n);
    for (int r = 0; r < n; r++)
      for (int k = 0; k < 6; k++) put(NODE[8*k +: 8]);
  endtask

  task automatic add_fill(input int n);
    for (int i = 0; i < n; i++) put(8'h20 + 8'(i % 64));
  endtask

  task automatic add_crc();
    put(8'hA5); put(8'h3C); put(8'h0F); put(8'h96);
  endtask

  task automatic send(input bit crc, input bit hit, input bit with_sof, input bit clr_eof);
    for (int i = 0; i < flen; i++) begin
      @(negedge clk_i);
      rx_valid_i    = 1'b1;
      rx_data_i     = frm[i];
      rx_sof_i      = with_sof && (i == 0);
      rx_eof_i      = (i == flen - 1);
      rx_crc_ok_i   = (i == flen - 1) && crc;
      rx_addr_hit_i = (i == flen - 1) && hit;
      pme_clr_i     = (i == flen - 1) && clr_eof;
    end
    @(negedge clk_i);
    rx_valid_i = 1'b0; rx_sof_i = 1'b0; rx_eof_i = 1'b0;
    rx_crc_ok_i = 1'b0; rx_addr_hit_i = 1'b0; pme_clr_i = 1'b0;
  endtask

  task automatic do_clear(input string tag);
    @(negedge clk_i); pme_clr_i = 1'b1;
    @(negedge clk_i); pme_clr_i = 1'b0;
    chk_pme(1'b1, tag);
  endtask

  task automatic t_offset0();
    add_hdr(1'b0); add_sync(6); add_reps(16); add_crc();
    send(1, 1, 1, 0);
    chk_pme(1'b0, "R4 R3 R6 pattern at payload offset 0");
    do_clear("R8 clear after offset-0 wake");
  endtask

  task automatic t_deep();
    add_hdr(1'b1); add_fill(40); add_sync(6); add_reps(16); add_fill(20); add_crc();
    send(1, 1, 1, 0);
    chk_pme(1'b0, "R4 pattern deep in payload");
    do_clear("R8 clear after deep wake");
  endtask

  task automatic t_long_sync();
    add_hdr(1'b0); add_fill(3); add_sync(17); add_reps(16); add_crc();
    send(1, 1, 1, 0);
    chk_pme(1'b0, "R2 seventeen-byte 0xFF prefix");
    do_clear("R8 clear after long-sync wake");
  endtask

  task automatic t_corrupt();
    add_hdr(1'b0); add_sync(6); add_reps(7);
    put(8'h11); put(8'h22); put(8'h00); put(8'h44); put(8'h55); put(8'h66);
    add_reps(8); add_crc();
    send(1, 1, 1, 0);
    chk_pme(1'b1, "R5 corrupted byte in eighth copy");
  endtask

  task automatic t_restart();
    add_hdr(1'b0); add_sync(6); add_reps(3); add_sync(6); add_reps(16); add_crc();
    send(1, 1, 1, 0);
    chk_pme(1'b0, "R5 pattern right after partial match");
    do_clear("R8 clear after restart wake");
  endtask

  task automatic t_short();
    add_hdr(1'b0); add_sync(6); add_reps(15); add_fill(10); add_crc();
    send(1, 1, 1, 0);
    chk_pme(1'b1, "R7 only fifteen copies");
  endtask

  task automatic t_bad_crc();
    add_hdr(1'b0); add_sync(6); add_reps(16); add_crc();
    send(0, 1, 1, 0);
    chk_pme(1'b1, "R6 bad CRC");
  endtask

  task automatic t_no_hit();
    add_hdr(1'b0); add_sync(6); add_reps(16); add_crc();
    send(1, 0, 1, 0);
    chk_pme(1'b1, "R6 destination not accepted");
  endtask

  task automatic t_disabled();
    add_hdr(1'b0); add_sync(6); add_reps(16); add_crc();
    pm_en_i = 1'b0;
    send(1, 1, 1, 0);
    chk_pme(1'b1, "R1 global enable clear");
    pm_en_i = 1'b1; magic_en_i = 1'b0;
    send(1, 1, 1, 0);
    chk_pme(1'b1, "R1 magic enable clear");
    magic_en_i = 1'b1;
  endtask

  task automatic t_reversed();
    add_hdr(1'b0); add_sync(6);
    for (int r = 0; r < 16; r++)
      for (int k = 5; k >= 0; k--) put(NODE[8*k +: 8]);
    add_crc();
    send(1, 1, 1, 0);
    chk_pme(1'b1, "R3 reversed byte order");
  endtask

  task automatic t_split();
    add_hdr(1'b0); add_sync(6); add_reps(8);
    send(1, 1, 1, 0);
    chk_pme(1'b1, "R9 first half of split pattern");
    flen = 0; add_reps(8); add_crc();
    send(1, 1, 1, 0);
    chk_pme(1'b1, "R9 second half of split pattern");
  endtask

  task automatic t_outside();
    flen = 0; add_sync(6); add_reps(16); add_crc();
    send(1, 1, 0, 0);
    chk_pme(1'b1, "R9 bytes outside a frame");
  endtask

  task automatic t_sticky();
    add_hdr(1'b0); add_sync(6); add_reps(16); add_crc();
    send(1, 1, 1, 0);
    chk_pme(1'b0, "R8 wake before sticky test");
    add_hdr(1'b0); add_fill(30); add_crc();
    send(1, 1, 1, 0);
    chk_pme(1'b0, "R8 stays low across plain frame");
    repeat (5) @(negedge clk_i);
    chk_pme(1'b0, "R8 stays low when idle");
    do_clear("R8 clear pulse raises");
    add_hdr(1'b0); add_sync(6); add_reps(16); add_crc();
    send(1, 1, 1, 1);
    chk_pme(1'b0, "R8 wake wins over same-cycle clear");
    do_clear("R8 clear after set-wins");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_pme(1'b1, "R10 during reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_pme(1'b1, "R10 after reset");
    t_offset0();
    t_deep();
    t_long_sync();
    t_corrupt();
    t_restart();
    t_short();
    t_bad_crc();
    t_no_hit();
    t_disabled();
    t_reversed();
    t_split();
    t_outside();
    t_sticky();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule